// File: doc/BRIEF.md
# Bidirectional Reference Pixel Shift Window

This block keeps a square window of reference pixels (16 by 16 by default) in registers. A block-matching cost tree reads all of it at once. The window follows a serpentine path through a search area. It moves down one column of candidate positions, steps one pixel to the right, moves up the next column, and repeats. On every move it takes in only the single line of pixels that enters the window and keeps all the others.

A command input picks the move for each cycle: hold, move down, move up or move right. A vertical move takes a new row at the bottom or top edge. A right move takes a new column at the right edge. A fill tracker watches the loads made after a clear. After sixteen vertical loads it raises a window-valid flag, which tells the consumer that every later move presents a complete new candidate.

Top module: `ref_shift_window`

## Requirements
- R1: While `rst` is high at a clock edge, every pixel is set to zero and `win_valid` falls, both visible after that edge.
- R2: Command 0 (hold) leaves every pixel unchanged.
- R3: Command 1 (move down) sets each row r below 15 to the old row r+1, and loads the input vector into row 15. Input element i, at bits [i*PIX_W +: PIX_W], goes to column i.
- R4: Command 2 (move up) sets each row r above 0 to the old row r-1, and loads the input vector into row 0. Element i goes to column i.
- R5: Command 3 (move right) sets each column c below 15 to the old column c+1, and loads the input vector into column 15. Element i goes to row i.
- R6: The output is raster ordered. Pixel (row r, column c) is at bits [(r*DIM+c)*PIX_W +: PIX_W] of `win_out`. Row 0 is at the top and column 0 is at the left.
- R7: `win_valid` rises in the cycle after the 16th vertical load (command 1 or 2, in any mix) that follows a clear or reset. After 15 such loads it is still low.
- R8: While `win_valid` is low, a right move restarts the fill count from zero and a hold leaves the count as it is.
- R9: Once `win_valid` is high, it stays high through every command until a clear or reset.
- R10: `clr` high at an edge acts like reset, whatever `cmd` is. The array is zeroed and `win_valid` drops.

Top module port list order is given below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of array and fill state |
| cmd | input | 2 | 0 hold, 1 move down, 2 move up, 3 move right |
| vec_in | input | DIM*PIX_W | Entering row or column, element i at bits [i*PIX_W +: PIX_W] |
| win_out | output | DIM*DIM*PIX_W | Window contents in raster order |
| win_valid | output | 1 | Window holds a complete candidate |

## Verification
A fill with pixel values that encode their own load number and lane shows the raster layout and the entry edge. It also shows whether row order or column order was swapped. Directed runs of 15 and 16 loads, a right move part way through a fill, and holds inside a fill separate a correct fill count from one that is off by one, never restarts, or restarts on a hold. A long random mix of all four commands, with rare clears, compares every cycle against a bench model. This catches a wrong neighbour source on any edge and a valid flag that drops after it has risen.

// File: rtl/ref_win_pkg.sv
package ref_win_pkg;
  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_DOWN  = 2'd1,
    SH_UP    = 2'd2,
    SH_RIGHT = 2'd3
  } shift_cmd_e;
endpackage

// File: rtl/rw_pixel_cell.sv
module rw_pixel_cell
  import ref_win_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  shift_cmd_e       sel,
  input  logic [PIX_W-1:0] src_dn,
  input  logic [PIX_W-1:0] src_up,
  input  logic [PIX_W-1:0] src_rt,
  output logic [PIX_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else begin
      case (sel)
        SH_DOWN:  q <= src_dn;
        SH_UP:    q <= src_up;
        SH_RIGHT: q <= src_rt;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/rw_pixel_grid.sv
module rw_pixel_grid
  import ref_win_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DIM   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  shift_cmd_e               sel,
  input  logic [DIM*PIX_W-1:0]     line_in,
  output logic [DIM*DIM*PIX_W-1:0] grid
);
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      logic [PIX_W-1:0] s_dn;
      logic [PIX_W-1:0] s_up;
      logic [PIX_W-1:0] s_rt;

      if (r == DIM-1) begin : g_bot
        assign s_dn = line_in[c*PIX_W +: PIX_W];
      end else begin : g_mid_dn
        assign s_dn = grid[((r+1)*DIM+c)*PIX_W +: PIX_W];
      end

      if (r == 0) begin : g_top
        assign s_up = line_in[c*PIX_W +: PIX_W];
      end else begin : g_mid_up
        assign s_up = grid[((r-1)*DIM+c)*PIX_W +: PIX_W];
      end

      if (c == DIM-1) begin : g_edge
        assign s_rt = line_in[r*PIX_W +: PIX_W];
      end else begin : g_mid_rt
        assign s_rt = grid[(r*DIM+c+1)*PIX_W +: PIX_W];
      end

      rw_pixel_cell #(.PIX_W(PIX_W)) u_cell (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .sel    (sel),
        .src_dn (s_dn),
        .src_up (s_up),
        .src_rt (s_rt),
        .q      (grid[(r*DIM+c)*PIX_W +: PIX_W])
      );
    end
  end
endmodule

// File: rtl/rw_fill_tracker.sv
module rw_fill_tracker
  import ref_win_pkg::*;
#(
  parameter int DIM = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  shift_cmd_e sel,
  output logic       full
);
  localparam int CW = $clog2(DIM + 1);

  logic [CW-1:0] loads;
  logic          vert;

  assign vert = (sel == SH_DOWN) || (sel == SH_UP);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      loads <= '0;
      full  <= 1'b0;
    end else if (!full) begin
      if (vert) begin
        loads <= loads + 1'b1;
        if (loads == CW'(DIM - 1)) full <= 1'b1;
      end else if (sel == SH_RIGHT) begin
        loads <= '0;
      end
    end
  end
endmodule

// File: rtl/ref_shift_window.sv
module ref_shift_window
  import ref_win_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DIM   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic [1:0]               cmd,
  input  logic [DIM*PIX_W-1:0]     vec_in,
  output logic [DIM*DIM*PIX_W-1:0] win_out,
  output logic                     win_valid
);
  shift_cmd_e sel;
  assign sel = shift_cmd_e'(cmd);

  rw_pixel_grid #(.PIX_W(PIX_W), .DIM(DIM)) u_grid (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .sel     (sel),
    .line_in (vec_in),
    .grid    (win_out)
  );

  rw_fill_tracker #(.DIM(DIM)) u_fill (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .sel  (sel),
    .full (win_valid)
  );
endmodule

// File: rtl/rw_window_checker.sv
module rw_window_checker #(
  parameter int PIX_W = 8,
  parameter int DIM   = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     clr,
  input logic [1:0]               cmd,
  input logic [DIM*PIX_W-1:0]     vec_in,
  input logic [DIM*DIM*PIX_W-1:0] win_out,
  input logic                     win_valid
);
  localparam int LW = DIM * PIX_W;
  localparam int TW = DIM * DIM * PIX_W;

  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (win_out == '0) && !win_valid);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && cmd == 2'd0) |=> $stable(win_out));

  assert_down_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && cmd == 2'd1) |=>
      (win_out[TW-LW-1:0] == $past(win_out[TW-1:LW])) &&
      (win_out[TW-1 -: LW] == $past(vec_in)));

  assert_up_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && cmd == 2'd2) |=>
      (win_out[TW-1:LW] == $past(win_out[TW-LW-1:0])) &&
      (win_out[LW-1:0] == $past(vec_in)));

  for (genvar r = 0; r < DIM; r++) begin : g_rchk
    assert_right_shift_R5: assert property (@(posedge clk) disable iff (rst)
      (!clr && cmd == 2'd3) |=>
        (win_out[r*LW +: (DIM-1)*PIX_W] == $past(win_out[r*LW+PIX_W +: (DIM-1)*PIX_W])) &&
        (win_out[r*LW+(DIM-1)*PIX_W +: PIX_W] == $past(vec_in[r*PIX_W +: PIX_W])));
  end

  assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !clr) |=> win_valid);

  assert_valid_rise_vertical_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(win_valid) |-> ($past(cmd) == 2'd1 || $past(cmd) == 2'd2));
endmodule

bind ref_shift_window rw_window_checker #(.PIX_W(PIX_W), .DIM(DIM)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .cmd       (cmd),
  .vec_in    (vec_in),
  .win_out   (win_out),
  .win_valid (win_valid)
);

// File: tb/sim_ref_shift_window.sv
module sim_ref_shift_window;
  localparam int CLK_P = 10;
  localparam int W = 8;
  localparam int D = 16;
  localparam int N = D * D;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           clr = 1'b0;
  logic [1:0]     cmd = 2'd0;
  logic [D*W-1:0] vec = '0;
  wire  [N*W-1:0] win;
  wire            vld;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m [D][D];
  int           m_cnt;
  bit           m_vld;

  always #(CLK_P/2) clk = ~clk;

  ref_shift_window #(.PIX_W(W), .DIM(D)) u0 (
    .clk(clk), .rst(rst), .clr(clr), .cmd(cmd),
    .vec_in(vec), .win_out(win), .win_valid(vld)
  );

  function automatic logic [N*W-1:0] pack_model();
    logic [N*W-1:0] f;
    for (int r = 0; r < D; r++)
      for (int c = 0; c < D; c++)
        f[(r*D+c)*W +: W] = m[r][c];
    return f;
  endfunction

  task automatic model_step(input bit c, input logic [1:0] k, input logic [D*W-1:0] v);
    logic [W-1:0] o [D][D];
    o = m;
    if (rst || c) begin
      for (int r = 0; r < D; r++)
        for (int q = 0; q < D; q++) m[r][q] = '0;
      m_cnt = 0;
      m_vld = 0;
    end else begin
      case (k)
        2'd1: for (int r = 0; r < D; r++)
                for (int q = 0; q < D; q++)
                  m[r][q] = (r == D-1) ? v[q*W +: W] : o[r+1][q];
        2'd2: for (int r = 0; r < D; r++)
                for (int q = 0; q < D; q++)
                  m[r][q] = (r == 0) ? v[q*W +: W] : o[r-1][q];
        2'd3: for (int r = 0; r < D; r++)
                for (int q = 0; q < D; q++)
                  m[r][q] = (q == D-1) ? v[r*W +: W] : o[r][q+1];
        default: ;
      endcase
      if (!m_vld) begin
        if (k == 2'd1 || k == 2'd2) begin
          m_cnt++;
          if (m_cnt == D) m_vld = 1;
        end else if (k == 2'd3) begin
          m_cnt = 0;
        end
      end
    end
  endtask

  task automatic chk_win(input string tag, input logic [N*W-1:0] exp);
    checks++;
    if (win !== exp) begin
      errors++;
      $display("FAIL %s window actual %h expected %h", tag, win, exp);
    end
  endtask

  task automatic chk_vld(input string tag, input bit exp);
    checks++;
    if (vld !== exp) begin
      errors++;
      $display("FAIL %s win_valid actual %b expected %b", tag, vld, exp);
    end
  endtask

  task automatic step(input bit c, input logic [1:0] k, input logic [D*W-1:0] v);
    string tw, tv;
    bit was_vld;
    was_vld = m_vld;
    clr = c; cmd = k; vec = v;
    @(posedge clk);
    model_step(c, k, v);
    @(negedge clk);
    if (c) tw = "R10";
    else case (k)
      2'd0: tw = "R2";
      2'd1: tw = "R3";
      2'd2: tw = "R4";
      default: tw = "R5";
    endcase
    tv = c ? "R10" : (was_vld ? "R9" : "R7");
    chk_win(tw, pack_model());
    chk_vld(tv, m_vld);
  endtask

  function automatic logic [D*W-1:0] rnd_vec();
    logic [D*W-1:0] v;
    for (int i = 0; i < D; i++) v[i*W +: W] = W'($urandom);
    return v;
  endfunction

  function automatic logic [D*W-1:0] tag_vec(input int k);
    logic [D*W-1:0] v;
    for (int i = 0; i < D; i++) v[i*W +: W] = {k[3:0], i[3:0]};
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    model_step(1'b1, 2'd0, '0);
    // R1: reset state
    chk_win("R1", '0);
    chk_vld("R1", 1'b0);
    rst = 1'b0;

    // R6 R7: fill with coded rows via down moves
    for (int k = 0; k < D - 1; k++) step(1'b0, 2'd1, tag_vec(k));
    chk_vld("R7 after 15 loads", 1'b0);
    step(1'b0, 2'd1, tag_vec(D - 1));
    chk_vld("R7 after 16 loads", 1'b1);
    ok = 1;
    for (int r = 0; r < D; r++)
      for (int c = 0; c < D; c++)
        if (win[(r*D+c)*W +: W] !== {r[3:0], c[3:0]}) ok = 0;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R6 raster layout actual %h expected pixel(r,c)={r,c}", win[W*4-1:0]);
    end

    // R9 R5 R4 R2: moves after valid
    step(1'b0, 2'd3, rnd_vec());
    step(1'b0, 2'd2, rnd_vec());
    step(1'b0, 2'd0, rnd_vec());
    step(1'b0, 2'd2, rnd_vec());

    // R10: clear while a move is commanded
    step(1'b1, 2'd1, rnd_vec());
    chk_win("R10 zeroed", '0);

    // R8: right move during fill restarts count
    for (int k = 0; k < 10; k++) step(1'b0, 2'd1, rnd_vec());
    step(1'b0, 2'd3, rnd_vec());
    for (int k = 0; k < D - 1; k++) step(1'b0, (k % 2) ? 2'd2 : 2'd1, rnd_vec());
    chk_vld("R8 restart after right", 1'b0);
    step(1'b0, 2'd2, rnd_vec());
    chk_vld("R8 full after restart", 1'b1);

    // R8: holds inside a fill keep the count
    step(1'b1, 2'd0, rnd_vec());
    for (int k = 0; k < 8; k++) step(1'b0, 2'd2, rnd_vec());
    for (int k = 0; k < 3; k++) step(1'b0, 2'd0, rnd_vec());
    for (int k = 0; k < 7; k++) step(1'b0, 2'd1, rnd_vec());
    chk_vld("R8 hold keeps count low", 1'b0);
    step(1'b0, 2'd1, rnd_vec());
    chk_vld("R8 hold keeps count full", 1'b1);

    // random serpentine-like mix
    for (int n = 0; n < 3000; n++)
      step(($urandom % 97) == 0, 2'($urandom % 4), rnd_vec());

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule